// File: doc/BRIEF.md
# Serial Register Port with Automatic Clock Polarity

This block is a serial slave that connects a four-wire style serial link (active-high chip enable, serial clock, data in, data out) to a parallel register bus. Each transfer opens with a command byte. The command gives the direction, picks one of two 32-location regions (a general storage region and a timekeeping-register region) and supplies a starting location. One or more data bytes then follow, and the location advances after each one. The storage array and the timekeeping registers sit outside the block and answer on the parallel bus.

The idle level of the serial clock is not configured. The block samples it at the moment chip enable rises. The edge that leaves the idle level is the shift edge, on which output data changes. The edge that returns to the idle level is the strobe edge, on which input data is latched. All three serial inputs pass through a synchroniser into the system clock domain, and all work is done on detected edges. A read fetches the next byte early, so its most significant bit is ready on the first shift edge of that byte.

Top module: `spi_regport`

## Requirements
- R1: While chip enable is low, `miso_oe` is 0, `bus_wr` and `bus_rd` stay 0, and serial clock or data activity has no effect.
- R2: The serial clock level seen when chip enable rises is taken as the idle level for the whole transfer. MOSI is latched on each edge back to that level, and MISO changes on each edge away from it. Both idle levels work the same way.
- R3: The first byte after chip enable rises is the command. Bit 7 = 1 selects a write and 0 a read. Bit 5 = 1 selects the timekeeping region and 0 the storage region. Bits 4..0 give the starting location. The first bus access uses `bus_addr` = {bit 5, bits 4..0}.
- R4: Command and data bytes travel most significant bit first, with one serial clock cycle per bit, on both MOSI and MISO.
- R5: In a write, each complete data byte produces one single-cycle `bus_wr` pulse that carries the byte on `bus_wdata` and its location on `bus_addr`.
- R6: In a read, one single-cycle `bus_rd` pulse is issued when the command completes and one after each data byte. `bus_rdata` is taken one system clock after the pulse and returned on MISO.
- R7: After each data byte the location advances by one, with `bus_addr` bit 5 held. Location 1Fh is followed by 00h, and 3Fh by 20h.
- R8: A command with bit 6 = 1 is ignored. No bus pulse is issued and `miso_oe` stays 0 until chip enable falls.
- R9: Only the first byte of a transfer is decoded as a command. Later bytes are data even if they look like commands, so a new command needs chip enable to go low and then high again.
- R10: `miso_oe` stays 0 for the whole of a write. In a read it stays 0 through the command byte and rises on the first shift edge of the first data byte.
- R11: If chip enable falls partway through a byte, that byte produces no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable, active high, asynchronous to clk |
| sck | input | 1 | Serial clock, either idle level |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the MISO driver |
| bus_addr | output | 6 | Region bit and location of the current access |
| bus_wdata | output | 8 | Write data |
| bus_wr | output | 1 | Single-cycle write strobe |
| bus_rd | output | 1 | Single-cycle read strobe |
| bus_rdata | input | 8 | Read data, valid one clk after `bus_rd` |

## Verification
The assertions assume the serial inputs are slow compared with clk. Each half period of the serial clock must last several system clocks, MOSI must stay steady across each strobe edge, and chip enable may change only while the serial clock rests at its idle level. They also assume that `bus_rdata` is presented on the cycle after the read strobe. The bench meets these conditions: every serial half period is eight system clocks, MOSI changes only on shift edges, and idle gaps surround each chip-enable change. The bench's register model answers reads with a one-cycle registered lookup.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  typedef enum logic [1:0] {
    XS_CMD  = 2'd0,
    XS_WR   = 2'd1,
    XS_RD   = 2'd2,
    XS_HOLD = 2'd3
  } xfer_state_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_edge_unit.sv
module spi_edge_unit (
  input  logic clk,
  input  logic rst,
  input  logic ce_s,
  input  logic sck_s,
  output logic idle_pol,
  output logic lead,
  output logic trail
);

  logic sck_q;
  logic ce_q;
  logic sck_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      ce_q     <= 1'b0;
      idle_pol <= 1'b0;
    end else begin
      sck_q <= sck_s;
      ce_q  <= ce_s;
      if (ce_s && !ce_q) idle_pol <= sck_s;
    end
  end

  assign sck_edge = ce_s && ce_q && (sck_s != sck_q);
  assign lead     = sck_edge && (sck_s != idle_pol);
  assign trail    = sck_edge && (sck_s == idle_pol);

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_regport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOC_W  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce_on,
  input  logic                lead,
  input  logic                trail,
  input  logic                mosi_s,
  input  logic [DATA_W-1:0]   bus_rdata,
  output logic                miso,
  output logic                miso_oe,
  output logic [LOC_W:0]      bus_addr,
  output logic [DATA_W-1:0]   bus_wdata,
  output logic                bus_wr,
  output logic                bus_rd
);

  localparam int CNT_W   = $clog2(DATA_W);
  localparam int AW      = LOC_W + 1;
  localparam int WR_BIT  = DATA_W - 1;
  localparam int RSV_BIT = DATA_W - 2;

  xfer_state_t        state;
  logic [CNT_W-1:0]   bit_cnt;
  logic [DATA_W-2:0]  rx_sh;
  logic [DATA_W-1:0]  tx_sh;
  logic [AW-1:0]      ptr;
  logic               rd_pend;
  logic [DATA_W-1:0]  rx_byte;
  logic               byte_done;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    step_addr = {a[AW-1], a[LOC_W-1:0] + 1'b1};
  endfunction

  assign rx_byte   = {rx_sh, mosi_s};
  assign byte_done = trail && (bit_cnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= XS_CMD;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      rd_pend   <= 1'b0;
      miso      <= 1'b0;
      miso_oe   <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
    end else if (!ce_on) begin
      state   <= XS_CMD;
      bit_cnt <= '0;
      rx_sh   <= '0;
      rd_pend <= 1'b0;
      miso_oe <= 1'b0;
      bus_wr  <= 1'b0;
      bus_rd  <= 1'b0;
    end else begin
      bus_wr  <= 1'b0;
      bus_rd  <= 1'b0;
      rd_pend <= bus_rd;
      if (rd_pend) tx_sh <= bus_rdata;
      if (lead && state == XS_RD) begin
        miso    <= tx_sh[DATA_W-1];
        tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
        miso_oe <= 1'b1;
      end
      if (trail) begin
        rx_sh   <= rx_byte[DATA_W-2:0];
        bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
      end
      if (byte_done) begin
        case (state)
          XS_CMD: begin
            if (rx_byte[RSV_BIT]) begin
              state <= XS_HOLD;
            end else begin
              ptr      <= rx_byte[AW-1:0];
              bus_addr <= rx_byte[AW-1:0];
              if (rx_byte[WR_BIT]) begin
                state <= XS_WR;
              end else begin
                state  <= XS_RD;
                bus_rd <= 1'b1;
              end
            end
          end
          XS_WR: begin
            bus_addr  <= ptr;
            bus_wdata <= rx_byte;
            bus_wr    <= 1'b1;
            ptr       <= step_addr(ptr);
          end
          XS_RD: begin
            bus_addr <= step_addr(ptr);
            bus_rd   <= 1'b1;
            ptr      <= step_addr(ptr);
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int DATA_W      = 8,
  parameter int LOC_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic [LOC_W:0]    bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int ADDR_W = LOC_W + 1;

  logic [2:0] sync_q;
  logic       ce_sync;
  logic       sck_sync;
  logic       mosi_sync;
  logic       idle_pol;
  logic       lead;
  logic       trail;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ce, sck, mosi}),
    .q   (sync_q)
  );

  assign {ce_sync, sck_sync, mosi_sync} = sync_q;

  spi_edge_unit u_edge (
    .clk      (clk),
    .rst      (rst),
    .ce_s     (ce_sync),
    .sck_s    (sck_sync),
    .idle_pol (idle_pol),
    .lead     (lead),
    .trail    (trail)
  );

  spi_xfer_ctrl #(.DATA_W(DATA_W), .LOC_W(LOC_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ce_on     (ce_sync),
    .lead      (lead),
    .trail     (trail),
    .mosi_s    (mosi_sync),
    .bus_rdata (bus_rdata),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd)
  );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
  input logic clk,
  input logic rst,
  input logic ce_sync,
  input logic idle_pol,
  input logic miso_oe,
  input logic bus_wr,
  input logic bus_rd,
  input logic rgn_bit
);

  logic have_acc;
  logic last_rgn;

  always_ff @(posedge clk) begin
    if (rst || !ce_sync) begin
      have_acc <= 1'b0;
      last_rgn <= 1'b0;
    end else if (bus_wr || bus_rd) begin
      have_acc <= 1'b1;
      last_rgn <= rgn_bit;
    end
  end

  assert_oe_off_R1: assert property (@(posedge clk) disable iff (rst)
    !ce_sync |=> !miso_oe);

  assert_no_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    !ce_sync |=> (!bus_wr && !bus_rd));

  assert_pol_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(ce_sync) && $past(ce_sync, 2)) |-> $stable(idle_pol));

  assert_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));

  assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> !bus_wr);

  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> !bus_rd);

  assert_region_R7: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && have_acc) |-> (rgn_bit == last_rgn));

  assert_wr_hiz_R10: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> !miso_oe);

endmodule

bind spi_regport spi_regport_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce_sync  (ce_sync),
  .idle_pol (idle_pol),
  .miso_oe  (miso_oe),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .rgn_bit  (bus_addr[ADDR_W-1])
);

// File: tb/tb_spi_regport.sv
`timescale 1ns/1ps
module tb_spi_regport;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  // {pol, cmd, d0, d1, a0, a1}
  localparam logic [36:0] VEC [8] = '{
    {1'b0, 8'h85, 8'hA5, 8'h3C, 6'h05, 6'h06},
    {1'b1, 8'h05, 8'hA5, 8'h3C, 6'h05, 6'h06},
    {1'b1, 8'h9F, 8'h11, 8'h22, 6'h1F, 6'h00},
    {1'b0, 8'h1F, 8'h11, 8'h22, 6'h1F, 6'h00},
    {1'b0, 8'hBF, 8'h5A, 8'hC3, 6'h3F, 6'h20},
    {1'b1, 8'h3F, 8'h5A, 8'hC3, 6'h3F, 6'h20},
    {1'b1, 8'hA2, 8'h0F, 8'hF0, 6'h22, 6'h23},
    {1'b0, 8'h22, 8'h0F, 8'hF0, 6'h22, 6'h23}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b0;
  logic       sck = 1'b0;
  logic       mosi = 1'b0;
  logic       miso;
  logic       miso_oe;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_rdata;

  logic [7:0] mem [64];
  int         wr_cnt = 0;
  int         rd_cnt = 0;
  logic [5:0] wr_a [256];
  logic [7:0] wr_d [256];
  logic [5:0] rd_a [256];

  logic [7:0] tx_b [4];
  logic [7:0] rx_b [4];
  int         oe_cmd_hi;
  int         oe_data_lo;
  int         oe_any_hi;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  spi_regport dut (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .sck       (sck),
    .mosi      (mosi),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // external register model: one-cycle read latency
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
      bus_rdata <= 8'h00;
    end else begin
      if (bus_wr) begin
        mem[bus_addr]        <= bus_wdata;
        wr_a[wr_cnt & 255]   <= bus_addr;
        wr_d[wr_cnt & 255]   <= bus_wdata;
        wr_cnt               <= wr_cnt + 1;
      end
      if (bus_rd) begin
        bus_rdata            <= mem[bus_addr];
        rd_a[rd_cnt & 255]   <= bus_addr;
        rd_cnt               <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic p, input int nbits);
    sck = p;
    mosi = 1'b0;
    repeat (4) @(negedge clk);
    ce = 1'b1;
    repeat (4) @(negedge clk);
    oe_cmd_hi = 0; oe_data_lo = 0; oe_any_hi = 0;
    for (int i = 0; i < nbits; i++) begin
      sck  = ~p;
      mosi = tx_b[i/8][7-(i%8)];
      repeat (HALF) @(negedge clk);
      rx_b[i/8][7-(i%8)] = miso;
      if (miso_oe) oe_any_hi++;
      if (i < 8) begin
        if (miso_oe) oe_cmd_hi++;
      end else if (!miso_oe) begin
        oe_data_lo++;
      end
      sck = p;
      repeat (HALF) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    ce = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int w0;
    int r0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1: reset state
    chk("R1", "oe after reset", 32'(miso_oe), 32'd0);
    chk("R1", "wr after reset", 32'(bus_wr), 32'd0);
    chk("R1", "rd after reset", 32'(bus_rd), 32'd0);

    // R1: serial activity with chip enable low
    w0 = wr_cnt; r0 = rd_cnt;
    for (int i = 0; i < 32; i++) begin
      sck = ~sck; mosi = i[1];
      repeat (HALF) @(negedge clk);
      if (miso_oe) oe_any_hi++;
    end
    sck = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1", "strobes with ce low", 32'((wr_cnt - w0) + (rd_cnt - r0)), 32'd0);
    chk("R1", "oe with ce low", 32'(miso_oe), 32'd0);

    // vector table walk
    for (int v = 0; v < 8; v++) begin
      logic       p;
      logic [7:0] cmd, d0, d1;
      logic [5:0] a0, a1;
      {p, cmd, d0, d1, a0, a1} = VEC[v];
      tx_b[0] = cmd; tx_b[1] = d0; tx_b[2] = d1; tx_b[3] = 8'h00;
      w0 = wr_cnt; r0 = rd_cnt;
      xfer(p, 24);
      if (cmd[7]) begin
        chk("R5", $sformatf("vec%0d write count", v), 32'(wr_cnt - w0), 32'd2);
        chk("R3", $sformatf("vec%0d first write addr", v), 32'(wr_a[w0 & 255]), 32'(a0));
        chk("R7", $sformatf("vec%0d second write addr", v), 32'(wr_a[(w0+1) & 255]), 32'(a1));
        chk("R4", $sformatf("vec%0d first write data", v), 32'(wr_d[w0 & 255]), 32'(d0));
        chk("R2", $sformatf("vec%0d second write data pol%0d", v, p), 32'(wr_d[(w0+1) & 255]), 32'(d1));
        chk("R10", $sformatf("vec%0d oe during write", v), 32'(oe_any_hi), 32'd0);
      end else begin
        chk("R6", $sformatf("vec%0d read strobes", v), 32'(rd_cnt - r0), 32'd3);
        chk("R3", $sformatf("vec%0d first read addr", v), 32'(rd_a[r0 & 255]), 32'(a0));
        chk("R7", $sformatf("vec%0d second read addr", v), 32'(rd_a[(r0+1) & 255]), 32'(a1));
        chk("R4", $sformatf("vec%0d first read byte", v), 32'(rx_b[1]), 32'(d0));
        chk("R2", $sformatf("vec%0d second read byte pol%0d", v, p), 32'(rx_b[2]), 32'(d1));
        chk("R10", $sformatf("vec%0d oe in cmd byte", v), 32'(oe_cmd_hi), 32'd0);
        chk("R10", $sformatf("vec%0d oe low in data", v), 32'(oe_data_lo), 32'd0);
      end
    end

    // R8: write command with bit 6 set is ignored
    tx_b[0] = 8'hC5; tx_b[1] = 8'h77;
    w0 = wr_cnt; r0 = rd_cnt;
    xfer(1'b0, 16);
    chk("R8", "writes after reserved cmd", 32'(wr_cnt - w0), 32'd0);

    // R8: read command with bit 6 set is ignored
    tx_b[0] = 8'h45; tx_b[1] = 8'h00;
    xfer(1'b1, 16);
    chk("R8", "reads after reserved cmd", 32'(rd_cnt - r0), 32'd0);
    chk("R8", "oe after reserved cmd", 32'(oe_any_hi), 32'd0);

    // R8: location 05h still holds its earlier value
    tx_b[0] = 8'h05; tx_b[1] = 8'h00;
    xfer(1'b0, 16);
    chk("R8", "location 05 unchanged", 32'(rx_b[1]), 32'hA5);

    // R11: chip enable drops mid-byte
    tx_b[0] = 8'h88; tx_b[1] = 8'hFF;
    w0 = wr_cnt;
    xfer(1'b0, 13);
    chk("R11", "write from partial byte", 32'(wr_cnt - w0), 32'd0);

    // R9: data that looks like a command is still data
    tx_b[0] = 8'h90; tx_b[1] = 8'h85; tx_b[2] = 8'h12; tx_b[3] = 8'hA0;
    w0 = wr_cnt;
    xfer(1'b1, 32);
    chk("R9", "burst write count", 32'(wr_cnt - w0), 32'd3);
    chk("R9", "command-like byte data", 32'(wr_d[w0 & 255]), 32'h85);
    chk("R9", "second burst addr", 32'(wr_a[(w0+1) & 255]), 32'h11);
    chk("R9", "third burst addr", 32'(wr_a[(w0+2) & 255]), 32'h12);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule